// File: doc/BRIEF.md
# Interleaved Cache Block Fill Controller

This block fetches one four-word cache block from four independent memory banks. The banks are interleaved by word, so each word of a block sits in a different bank. A block-fill request carries a block-aligned word address. The controller spends one cycle sending the row address, then starts the banks. Each bank is then busy for a fixed access time. The four words come back one per cycle on a single-word return bus, with a valid strobe and a last flag.

A parameter selects the sequencing. In interleaved mode all four banks start together, so their access times overlap and the block arrives after 15 cycles. In simple mode each word runs its own send, access and transfer steps in turn, so the block arrives after 48 cycles. A single-word write port preloads the bank storage. Writes and new requests are taken only while the controller is idle. A request whose address is not a multiple of four is refused with an error pulse.

Top module: `ilv_fill_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1 and `resp_valid`, `resp_last` and `req_err` are 0.
- R2: Word address `w` is stored in bank `w mod 4` at row `w / 4`. A fill of block base `b` returns the words last written at addresses `b`, `b+1`, `b+2` and `b+3`.
- R3: The words are returned in ascending address order, one per valid beat. `resp_last` is 1 only with the fourth word, and `resp_valid` drops in the cycle after the last word.
- R4: In interleaved mode, let the request be taken on clock edge A. Words 0 to 3 are valid in the cycles after edges A+11, A+12, A+13 and A+14. This gives a 15-cycle block penalty (1 send + 10 access + 1 transfer + 3).
- R5: In simple mode, word k is valid in the cycle after edge A+11+12k. This gives a 48-cycle block penalty (4 x (1+10+1)).
- R6: `req_ready` is 0 from edge A until the block has been returned and the banks are free. It is 1 again after edge A+15 in interleaved mode and after edge A+48 in simple mode. A request presented while `req_ready` is 0 is ignored.
- R7: A request taken while ready whose address has bits [1:0] not equal to 0 raises `req_err` for exactly one cycle, after that edge. No bank is started, no word is returned, and `req_ready` stays 1.
- R8: A write is performed only on an edge where `req_ready` is 1. A write presented while a fill is in progress leaves the storage unchanged.
- R9: A bank is never restarted while busy, and a word is never returned from a bank that is still inside its access time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Block-fill request strobe |
| req_addr | input | ADDR_W | Word address of the block, expected to be block-aligned |
| req_ready | output | 1 | Controller idle; requests and writes are taken |
| req_err | output | 1 | One-cycle pulse for a misaligned request |
| wr_en | input | 1 | Preload write strobe |
| wr_addr | input | ADDR_W | Word address for the write |
| wr_data | input | DATA_W | Write data |
| resp_valid | output | 1 | Return word valid |
| resp_data | output | DATA_W | Return word |
| resp_last | output | 1 | Marks the fourth word of the block |

## Verification
One interleaved instance and one simple-mode instance receive the same stimulus. Each returned beat is compared against an arrival cycle computed from the 1/10/1 timing model. The block bases are chosen at the start, middle and top of the address range. This separates an error in the bank selection from an error in the row selection, because a wrong row or bank gives a wrong word pattern. A fill is also disturbed mid-flight by a second request and a write, which shows whether the ready gating blocks both. Misaligned addresses with different low bits show whether the error path leaves the banks untouched.

// File: rtl/fill_pkg.sv
package fill_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEND,
    ST_WAIT,
    ST_XFER
  } fill_state_t;
endpackage

// File: rtl/fill_bank.sv
// One memory bank: a single-port-style array with a separate write and a
// registered read, plus a busy timer that models the access/cycle time.
module fill_bank #(
  parameter int DATA_W = 32,
  parameter int ROW_W  = 6,
  parameter int BUSY   = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_start,
  input  logic [ROW_W-1:0]  rd_row,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy
);
  localparam int DEPTH = 1 << ROW_W;
  localparam int CNT_W = $clog2(BUSY + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_q;
  logic [CNT_W-1:0]  busy_cnt;

  // Block-RAM friendly: no reset on the array or the read register.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_row] <= wr_data;
    if (rd_start) rd_q <= mem[rd_row];
  end

  always_ff @(posedge clk) begin
    if (rst) busy_cnt <= '0;
    else if (rd_start) busy_cnt <= CNT_W'(BUSY);
    else if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;
  end

  assign rd_data = rd_q;
  assign busy    = (busy_cnt != '0);

  assert_no_restart_R9: assert property (@(posedge clk) disable iff (rst)
    rd_start |-> !busy);
  assert_wr_idle_R8: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !busy);
endmodule

// File: rtl/fill_seq.sv
// Fill sequencer: accepts a request, issues the address phase, waits out the
// bank access time and streams the words; mode picks overlapped or serial.
module fill_seq
  import fill_pkg::*;
#(
  parameter int NB          = 4,
  parameter int ADDR_W      = 8,
  parameter int BUSY        = 10,
  parameter bit INTERLEAVED = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  input  logic [ADDR_W-1:0]         req_addr,
  output logic                      req_ready,
  output logic                      req_err,
  output logic [NB-1:0]             bank_start,
  output logic [ADDR_W-$clog2(NB)-1:0] row,
  output logic [$clog2(NB)-1:0]     word_idx,
  output logic                      resp_valid,
  output logic                      resp_last
);
  localparam int IDX_W = $clog2(NB);
  localparam int ROW_W = ADDR_W - IDX_W;
  localparam int CNT_W = (BUSY > 1) ? $clog2(BUSY) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NB - 1);
  localparam int PENALTY = INTERLEAVED ? (1 + BUSY + 1 + (NB - 1))
                                       : (NB * (1 + BUSY + 1));

  fill_state_t       state;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic [ROW_W-1:0]  row_q;
  logic              err_q;
  logic              accept;
  logic              aligned;

  assign aligned = (req_addr[IDX_W-1:0] == '0);
  assign accept  = (state == ST_IDLE) && req_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      idx   <= '0;
      row_q <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            if (!aligned) begin
              err_q <= 1'b1;
            end else begin
              row_q <= req_addr[ADDR_W-1:IDX_W];
              idx   <= '0;
              state <= ST_SEND;
            end
          end
        end
        ST_SEND: begin
          cnt   <= CNT_W'(BUSY - 1);
          state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (cnt == '0) state <= ST_XFER;
          else cnt <= cnt - 1'b1;
        end
        ST_XFER: begin
          if (idx == LAST_IDX) begin
            state <= ST_IDLE;
          end else begin
            idx <= idx + 1'b1;
            if (!INTERLEAVED) state <= ST_SEND;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  generate
    for (genvar b = 0; b < NB; b++) begin : g_start
      if (INTERLEAVED) begin : g_all
        assign bank_start[b] = (state == ST_SEND);
      end else begin : g_one
        assign bank_start[b] = (state == ST_SEND) && (idx == IDX_W'(b));
      end
    end
  endgenerate

  assign req_ready  = (state == ST_IDLE);
  assign req_err    = err_q;
  assign row        = row_q;
  assign word_idx   = idx;
  assign resp_valid = (state == ST_XFER);
  assign resp_last  = (state == ST_XFER) && (idx == LAST_IDX);

  // Cycles since the last accepted request, used only by the checks below.
  logic [15:0] chk_cnt;
  always_ff @(posedge clk) begin
    if (rst) chk_cnt <= '0;
    else if (accept && aligned) chk_cnt <= '0;
    else if (chk_cnt != 16'hFFFF) chk_cnt <= chk_cnt + 1'b1;
  end

  // Block penalty for the selected mode (R4 interleaved, R5 simple).
  assert_penalty_R4: assert property (@(posedge clk) disable iff (rst)
    resp_last |-> (chk_cnt == 16'(PENALTY - 1)));
  assert_last_ends_R3: assert property (@(posedge clk) disable iff (rst)
    resp_last |=> (!resp_valid && req_ready));
  assert_busy_after_accept_R6: assert property (@(posedge clk) disable iff (rst)
    (req_ready && req_valid && aligned) |=> !req_ready);
  assert_err_keeps_ready_R7: assert property (@(posedge clk) disable iff (rst)
    req_err |-> (req_ready && !resp_valid));
endmodule

// File: rtl/ilv_fill_ctrl.sv
// Top: word-interleaved bank array plus fill sequencer.
module ilv_fill_ctrl #(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int NB          = 4,
  parameter int BUSY        = 10,
  parameter bit INTERLEAVED = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              req_err,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_data,
  output logic              resp_last
);
  localparam int IDX_W = $clog2(NB);
  localparam int ROW_W = ADDR_W - IDX_W;

  logic [NB-1:0]     bank_start;
  logic [NB-1:0]     bank_busy;
  logic [DATA_W-1:0] bank_q [NB];
  logic [ROW_W-1:0]  row;
  logic [IDX_W-1:0]  word_idx;
  logic              wr_ok;

  assign wr_ok = wr_en && req_ready;

  fill_seq #(
    .NB(NB), .ADDR_W(ADDR_W), .BUSY(BUSY), .INTERLEAVED(INTERLEAVED)
  ) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .req_err(req_err),
    .bank_start(bank_start), .row(row), .word_idx(word_idx),
    .resp_valid(resp_valid), .resp_last(resp_last)
  );

  generate
    for (genvar b = 0; b < NB; b++) begin : g_bank
      logic sel_wr;
      assign sel_wr = wr_ok && (wr_addr[IDX_W-1:0] == IDX_W'(b));
      fill_bank #(.DATA_W(DATA_W), .ROW_W(ROW_W), .BUSY(BUSY)) u_bank (
        .clk(clk), .rst(rst),
        .wr_en(sel_wr), .wr_row(wr_addr[ADDR_W-1:IDX_W]), .wr_data(wr_data),
        .rd_start(bank_start[b]), .rd_row(row),
        .rd_data(bank_q[b]), .busy(bank_busy[b])
      );
    end
  endgenerate

  assign resp_data = bank_q[word_idx];

  assert_bank_done_R9: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> !bank_busy[word_idx]);
  assert_no_start_idle_R7: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (bank_start == '0));
endmodule

// File: tb/test_ilv_fill_ctrl.sv
`timescale 1ns/1ps
module test_ilv_fill_ctrl;
  localparam int DW = 32;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;

  logic rdy_i, err_i, rv_i, last_i;
  logic rdy_s, err_s, rv_s, last_s;
  logic [DW-1:0] d_i, d_s;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ilv_fill_ctrl #(.DATA_W(DW), .ADDR_W(AW), .INTERLEAVED(1'b1)) i_ilv_fill_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(rdy_i), .req_err(err_i), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .resp_valid(rv_i), .resp_data(d_i), .resp_last(last_i));

  ilv_fill_ctrl #(.DATA_W(DW), .ADDR_W(AW), .INTERLEAVED(1'b0)) i_ilv_fill_ctrl_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(rdy_s), .req_err(err_s), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .resp_valid(rv_s), .resp_data(d_s), .resp_last(last_s));

  function automatic logic [DW-1:0] pat(input int a);
    return 32'h5A00_0000 + 32'(a) * 32'h0001_0203;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    #1;
  endtask

  task automatic preload;
    for (int a = 0; a < 64; a++) begin
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = pat(a);
      step();
    end
    wr_en = 1'b0;
  endtask

  // Fill of one block on both instances; optionally disturbs mid-flight.
  task automatic fill_test(input int base, input bit disturb);
    int got_i = 0;
    int got_s = 0;
    while (!(rdy_i && rdy_s)) step();
    req_valid = 1'b1; req_addr = AW'(base);
    step();                       // edge A taken
    req_valid = 1'b0;
    chk(!rdy_i && !rdy_s, "R6 ready low after accept", {rdy_i, rdy_s}, 0);
    for (int n = 1; n <= 52; n++) begin
      step();
      if (disturb && n == 5) begin
        req_valid = 1'b1; req_addr = AW'((base + 8) % 256);
        wr_en = 1'b1; wr_addr = AW'(base + 1); wr_data = 32'hDEAD_BEEF;
      end
      if (disturb && n == 6) begin
        req_valid = 1'b0; wr_en = 1'b0;
      end
      if (rv_i) begin
        chk(got_i < 4 && n == 11 + got_i, "R4 interleaved beat cycle", n, 11 + got_i);
        chk(d_i == pat(base + got_i), "R2 interleaved data", d_i, pat(base + got_i));
        chk(last_i == (got_i == 3), "R3 interleaved last flag", last_i, got_i == 3);
        got_i++;
      end
      if (rv_s) begin
        chk(got_s < 4 && n == 11 + 12 * got_s, "R5 simple beat cycle", n, 11 + 12 * got_s);
        chk(d_s == pat(base + got_s), "R2 simple data", d_s, pat(base + got_s));
        chk(last_s == (got_s == 3), "R3 simple last flag", last_s, got_s == 3);
        got_s++;
      end
      if (n == 14) chk(!rdy_i, "R6 interleaved still busy", rdy_i, 0);
      if (n == 15) chk(rdy_i, "R6 interleaved ready again", rdy_i, 1);
      if (n == 47) chk(!rdy_s, "R6 simple still busy", rdy_s, 0);
      if (n == 48) chk(rdy_s, "R6 simple ready again", rdy_s, 1);
    end
    chk(got_i == 4, "R3 interleaved word count", got_i, 4);
    chk(got_s == 4, "R3 simple word count", got_s, 4);
    if (disturb) begin
      int extra = 0;
      for (int n = 0; n < 20; n++) begin
        step();
        if (rv_i || rv_s) extra++;
      end
      chk(extra == 0, "R6 busy request ignored", extra, 0);
    end
  endtask

  task automatic misalign_test(input int addr);
    int extra = 0;
    while (!(rdy_i && rdy_s)) step();
    req_valid = 1'b1; req_addr = AW'(addr);
    step();
    req_valid = 1'b0;
    chk(err_i && err_s, "R7 error pulse raised", {err_i, err_s}, 2'b11);
    chk(rdy_i && rdy_s, "R7 ready kept", {rdy_i, rdy_s}, 2'b11);
    step();
    chk(!err_i && !err_s, "R7 error one cycle", {err_i, err_s}, 0);
    for (int n = 0; n < 20; n++) begin
      step();
      if (rv_i || rv_s || !rdy_i || !rdy_s) extra++;
    end
    chk(extra == 0, "R7 no fill started", extra, 0);
  endtask

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst = 1'b0;
    #0;
    chk(rdy_i && rdy_s, "R1 ready after reset", {rdy_i, rdy_s}, 2'b11);
    chk(!rv_i && !rv_s && !last_i && !last_s, "R1 no response after reset",
        {rv_i, rv_s, last_i, last_s}, 0);
    chk(!err_i && !err_s, "R1 no error after reset", {err_i, err_s}, 0);
    preload();
    fill_test(0, 1'b0);
    fill_test(36, 1'b0);
    fill_test(60, 1'b0);
    fill_test(4, 1'b1);    // R8: write to word 5 during fill must be dropped
    fill_test(4, 1'b0);    // R8: re-read shows original word 5
    misalign_test(6);
    misalign_test(3);
    fill_test(12, 1'b0);   // R9: back-to-back after error path
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule